// File: doc/BRIEF.md
# Shared-Bus Register File with Clear-Then-Set Loading

This block holds eight 16-bit working registers that all talk over one common data bus. Each register is controlled by three strobes: a clear strobe that empties it, a write gate that lets ones on the bus set its bits, and a read gate that places its contents on the bus. Because a write gate can only set bits, a clean load takes two steps. The register is cleared in one cycle and then gated from the bus in a later one.

The bus is combinational. It carries the bitwise OR of every register whose read gate is high, plus an external source input. That input is how an adder result or a memory word enters the bank. Raising several read gates together therefore gives a Boolean OR in a single step. The buffer register also has a second read gate that puts the complement of its value on the bus, which supports subtraction and the derived AND and XOR operations.

Register strobes take effect on the rising clock edge. A register's value can be read and overwritten in the same cycle.

Top module: `busreg_bank`

## Requirements
- R1: After reset, every register holds zero, so a read of all eight registers at once yields 0x0000 on the bus.
- R2: With no read gate, no complement gate and a zero external source, the bus is 0x0000.
- R3: Raising the read gate of a register puts its stored value on the bus in the same cycle. Register indices are: 0 accumulator, 1 program counter, 2 adder input X, 3 adder input Y, 4 buffer, 5 return address, 6 memory address, 7 memory data.
- R4: Raising several read gates in one cycle puts the bitwise OR of the selected registers on the bus.
- R5: The complement gate puts the bitwise inverse of the buffer register (index 4) on the bus, ORed with any other sources.
- R6: A clear strobe makes the register zero from the next clock edge. A read of that register in the same cycle still shows the old value.
- R7: A write gate without a clear sets the register to its old value ORed with the bus value at that edge. Writing without a prior clear therefore merges the old and new values.
- R8: When the clear strobe and the write gate of one register are both high in the same cycle, the clear wins and the register becomes zero.
- R9: A register whose clear strobe and write gate are both low keeps its value, whatever the other registers and the bus do.
- R10: The external source input is ORed onto the bus together with any register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; zeroes every register |
| clr_strb | input | 8 | Per-register clear strobe, bit i for register i |
| wr_gate | input | 8 | Per-register write gate; sets register bits from bus ones |
| rd_gate | input | 8 | Per-register read gate; drives the register onto the bus |
| rd_cmp | input | 1 | Drives the complement of the buffer register onto the bus |
| ext_src | input | 16 | External value ORed onto the bus, such as an adder sum or a memory word |
| bus_q | output | 16 | Current bus value |

## Verification
The bench targets the write path that has no clear in front of it. A design that loaded the bus value instead of ORing it would lose the old accumulator bits, and the readback after such a write would show 0x0001 instead of 0x1235. It drives clear and write together on one register. A design that let the write win would read back 0xFFFF rather than zero. It reads a register in the cycle it is cleared and expects the old value, which catches a clear implemented combinationally. It also mixes the complement gate with a plain read and with the external source. An inverter on the wrong register, or one that replaced the bus instead of ORing into it, shows up as a wrong bit pattern.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
   typedef enum int unsigned {
      IDX_ACC   = 0,
      IDX_PC    = 1,
      IDX_ADDX  = 2,
      IDX_ADDY  = 3,
      IDX_BUF   = 4,
      IDX_RET   = 5,
      IDX_MADDR = 6,
      IDX_MDATA = 7
   } reg_idx_e;

   localparam int unsigned DEF_WIDTH = 16;
   localparam int unsigned DEF_NREGS = 8;
endpackage

// File: rtl/busreg_cell.sv
module busreg_cell #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("busreg_cell: WIDTH must be at least 1");
      end
   endgenerate

   // Set/reset storage: clear resets every bit, write sets bits that are 1 on the bus
   logic [WIDTH-1:0] set_vec;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      set_vec = wr ? bus_in : '0;
      if (clr) nxt = '0;
      else     nxt = q | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr) |=> (q == '0));

   // R7
   wr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> (q == ($past(q) | $past(bus_in))));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !clr) |=> $stable(q));
endmodule

// File: rtl/busreg_merge.sv
module busreg_merge #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned NREGS   = 8,
   parameter bit          HAS_CMP = 1'b1,
   parameter int unsigned CMP_IDX = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREGS-1:0][WIDTH-1:0] q_all,
   input  logic [NREGS-1:0]            rd,
   input  logic                        cmp,
   input  logic [WIDTH-1:0]            ext,
   output logic [WIDTH-1:0]            bus
);
   generate
      if (NREGS < 1) begin : g_bad_nregs
         $error("busreg_merge: NREGS must be at least 1");
      end
      if (CMP_IDX >= NREGS) begin : g_bad_cmp
         $error("busreg_merge: CMP_IDX out of range");
      end
   endgenerate

   // Contribution of the complemented read path, present only when configured
   logic [WIDTH-1:0] cmp_term;
   generate
      if (HAS_CMP) begin : g_cmp
         assign cmp_term = cmp ? ~q_all[CMP_IDX] : '0;
      end else begin : g_nocmp
         logic unused_cmp;
         assign unused_cmp = cmp;
         assign cmp_term   = '0;
      end
   endgenerate

   // Wired-OR of all active sources
   always_comb begin
      bus = ext | cmp_term;
      for (int i = 0; i < int'(NREGS); i++) begin
         if (rd[i]) bus = bus | q_all[i];
      end
   end

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd == '0) && !cmp && (ext == '0)) |-> (bus == '0));

   // R10
   ext_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus & ext) == ext));

   // R4
   generate
      for (genvar g = 0; g < int'(NREGS); g++) begin : g_rdchk
         rd_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd[g] |-> ((bus & q_all[g]) == q_all[g]));
      end
      if (HAS_CMP) begin : g_cmpchk
         // R5
         cmp_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmp |-> ((bus & ~q_all[CMP_IDX]) == ~q_all[CMP_IDX]));
      end
   endgenerate
endmodule

// File: rtl/busreg_bank.sv
module busreg_bank #(
   parameter int unsigned WIDTH   = busreg_pkg::DEF_WIDTH,
   parameter int unsigned NREGS   = busreg_pkg::DEF_NREGS,
   parameter bit          HAS_CMP = 1'b1,
   parameter int unsigned CMP_IDX = int'(busreg_pkg::IDX_BUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] clr_strb,
   input  logic [NREGS-1:0] wr_gate,
   input  logic [NREGS-1:0] rd_gate,
   input  logic             rd_cmp,
   input  logic [WIDTH-1:0] ext_src,
   output logic [WIDTH-1:0] bus_q
);
   localparam int unsigned LAST = NREGS - 1;

   generate
      if (LAST >= 64) begin : g_too_many
         $error("busreg_bank: NREGS too large");
      end
   endgenerate

   logic [NREGS-1:0][WIDTH-1:0] q_all;
   logic [WIDTH-1:0]            bus;

   generate
      for (genvar r = 0; r < int'(NREGS); r++) begin : g_reg
         busreg_cell #(.WIDTH(WIDTH)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_strb[r]),
            .wr     (wr_gate[r]),
            .bus_in (bus),
            .q      (q_all[r])
         );
      end
   endgenerate

   busreg_merge #(
      .WIDTH   (WIDTH),
      .NREGS   (NREGS),
      .HAS_CMP (HAS_CMP),
      .CMP_IDX (CMP_IDX)
   ) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .q_all (q_all),
      .rd    (rd_gate),
      .cmp   (rd_cmp),
      .ext   (ext_src),
      .bus   (bus)
   );

   assign bus_q = bus;

   // R8
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_strb[0] && wr_gate[0]) |=> (q_all[0] == '0));
endmodule

// File: tb/busreg_bank_bench.sv
module busreg_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  clr_strb = '0;
   logic [7:0]  wr_gate = '0;
   logic [7:0]  rd_gate = '0;
   logic        rd_cmp = 1'b0;
   logic [15:0] ext_src = '0;
   logic [15:0] bus_q;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   busreg_bank u_busreg_bank (
      .clk(clk), .rst_n(rst_n), .clr_strb(clr_strb), .wr_gate(wr_gate),
      .rd_gate(rd_gate), .rd_cmp(rd_cmp), .ext_src(ext_src), .bus_q(bus_q)
   );

   // vector: clr[56:49] wr[48:41] rd[40:33] cmp[32] ext[31:16] exp_bus[15:0]
   localparam int NV = 18;
   localparam logic [56:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'hFF, 1'b0, 16'h0000, 16'h0000}, // R1 all zero after reset
      {8'h00, 8'h01, 8'h00, 1'b0, 16'h1234, 16'h1234}, // R10 load acc from ext
      {8'h00, 8'h02, 8'h00, 1'b0, 16'h00F0, 16'h00F0}, // R10 load pc
      {8'h00, 8'h00, 8'h01, 1'b0, 16'h0000, 16'h1234}, // R3 read acc
      {8'h00, 8'h00, 8'h03, 1'b0, 16'h0000, 16'h12F4}, // R4 acc|pc
      {8'h00, 8'h10, 8'h00, 1'b0, 16'h0F0F, 16'h0F0F}, // R7 load buf
      {8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 16'hF0F0}, // R5 complement buf
      {8'h00, 8'h00, 8'h01, 1'b1, 16'h0000, 16'hF2F4}, // R5 complement | acc
      {8'h00, 8'h01, 8'h00, 1'b0, 16'h0001, 16'h0001}, // R7 write acc, no clear
      {8'h00, 8'h00, 8'h01, 1'b0, 16'h0000, 16'h1235}, // R7 merged value
      {8'h01, 8'h01, 8'h00, 1'b0, 16'hFFFF, 16'hFFFF}, // R8 clear+write acc
      {8'h00, 8'h00, 8'h01, 1'b0, 16'h0000, 16'h0000}, // R8 clear won
      {8'h02, 8'h00, 8'h02, 1'b0, 16'h0000, 16'h00F0}, // R6 old value visible
      {8'h00, 8'h00, 8'h12, 1'b0, 16'h0000, 16'h0F0F}, // R6 pc zero, R9 buf kept
      {8'h00, 8'h80, 8'h10, 1'b0, 16'h0000, 16'h0F0F}, // R3 buf -> mdata
      {8'h00, 8'h00, 8'h80, 1'b0, 16'h3000, 16'h3F0F}, // R10 ext | mdata
      {8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0000}, // R2 idle bus
      {8'h00, 8'h00, 8'hFF, 1'b0, 16'h0000, 16'h0F0F}  // R9 others untouched
   };
   localparam string TAG [NV] = '{
      "R1", "R10", "R10", "R3", "R4", "R7", "R5", "R5", "R7",
      "R7", "R8", "R8", "R6", "R9", "R3", "R10", "R2", "R9"
   };

   task automatic check(input string req, input logic [15:0] exp);
      n_cmp++;
      if (bus_q !== exp) begin
         n_bad++;
         $display("FAIL %s: bus actual %h expected %h", req, bus_q, exp);
      end
   endtask

   task automatic drive(input logic [7:0] c, input logic [7:0] w,
                        input logic [7:0] r, input logic m,
                        input logic [15:0] e);
      clr_strb = c; wr_gate = w; rd_gate = r; rd_cmp = m; ext_src = e;
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][56:49], VEC[i][48:41], VEC[i][40:33], VEC[i][32], VEC[i][31:16]);
         #3;
         check(TAG[i], VEC[i][15:0]);
      end

      // R6 then R7: proper clear-then-set load of return register (index 5)
      @(negedge clk); drive(8'h20, 8'h00, 8'h00, 1'b0, 16'h0000);
      @(negedge clk); drive(8'h00, 8'h20, 8'h00, 1'b0, 16'hAAAA);
      @(negedge clk); drive(8'h00, 8'h00, 8'h20, 1'b0, 16'h0000);
      #3; check("R7", 16'hAAAA);

      // R5 complement with buffer cleared gives all ones
      @(negedge clk); drive(8'h10, 8'h00, 8'h00, 1'b0, 16'h0000);
      @(negedge clk); drive(8'h00, 8'h00, 8'h00, 1'b1, 16'h0000);
      #3; check("R5", 16'hFFFF);

      // R1 reset in mid-run clears everything
      @(negedge clk); drive(8'h00, 8'h00, 8'h00, 1'b0, 16'h0000);
      rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      drive(8'h00, 8'h00, 8'hFF, 1'b0, 16'h0000);
      #3; check("R1", 16'h0000);

      @(negedge clk); drive(8'h00, 8'h00, 8'h00, 1'b0, 16'h0000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule